// File: doc/BRIEF.md
# Single-Cycle Control Word Decoder

This block is the purely combinational instruction decoder of a single-cycle processor core. It takes a 16-bit instruction word and turns it, within the same cycle, into a 20-bit control word. That word steers the register file addresses, the operand-B multiplexer, the function unit, the result multiplexer, the two write enables and the program-counter logic. It holds no state and has no clock.

The opcode space was laid out so that every control signal is one instruction bit or a two-bit product. The top three opcode bits pick the instruction class. The low four opcode bits feed the function select directly. The lowest opcode bit (instruction bit 9) has two uses: it is the branch-condition select for program-flow instructions, and an ordinary function-select bit everywhere else. Whenever the program counter is being loaded, the decoder masks that bit out of the function select.

The surrounding datapath drives the instruction memory output into `instr_word` and distributes the fields of `ctrl_word`. No state machine exists here: the house state-machine layout is dropped, and only its naming and layout conventions are kept.

Top module: `ctl_decode`

## Requirements
- R1: Register selects pass through unchanged: `ctrl_word[19:17]` = `instr_word[8:6]` (destination), `ctrl_word[16:14]` = `instr_word[5:3]` (source A), `ctrl_word[13:11]` = `instr_word[2:0]` (source B).
- R2: When `instr_word[15:14]` is not `11`, the function select `ctrl_word[9:6]` equals `instr_word[12:9]`.
- R3: When `instr_word[15:14]` is `11`, the function select `ctrl_word[9:6]` equals `{instr_word[12:10], 1'b0}`, meaning bit 9 is masked out.
- R4: The constant-operand select `ctrl_word[10]` equals `instr_word[15]`. The register-and-constant class (`instr_word[15:13]` = `100`) therefore yields constant select 1, result select 0 and register write 1.
- R5: The result-from-memory select `ctrl_word[5]` equals `instr_word[13]`. The memory-read class (`001`) therefore yields result select 1, register write 1 and constant select 0.
- R6: The register write enable `ctrl_word[4]` equals the inverse of `instr_word[14]`. It is 1 for the `000`, `001` and `100` classes and 0 for the store class and for program-flow instructions.
- R7: The memory write enable `ctrl_word[3]` is 1 exactly when `instr_word[15:14]` = `01`. It is never 1 at the same time as the register write enable.
- R8: The program-counter load `ctrl_word[2]` is 1 exactly when `instr_word[15:14]` = `11`. When it is 1, both write enables are 0.
- R9: The jump select `ctrl_word[1]` equals `instr_word[13]`, and the negative-condition select `ctrl_word[0]` equals `instr_word[9]`. For example, the branch-on-negative opcode `1100001` gives `ctrl_word[0]` = 1 with a function select of `0000`.
- R10: The full control word is a pure function of the current instruction. It follows every change of `instr_word` with no clock and no retained state. For example, `instr_word` = `0x84BB` gives `0x5DC90` and `0x0000` gives `0x00010`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 16 | Instruction: opcode in 15:9, destination or offset-high in 8:6, source A in 5:3, source B, constant or offset-low in 2:0 |
| ctrl_word | output | 20 | Control word: dest 19:17, srcA 16:14, srcB 13:11, const sel 10, function 9:6, mem result sel 5, reg write 4, mem write 3, PC load 2, jump 1, negative cond 0 |

## Verification
The bound checker takes for granted that `instr_word` is fully known. It evaluates a property only when the input carries no X or Z bits, because an undriven instruction would otherwise make the class relations meaningless. The bench honours this by driving a defined word from time zero. Every later stimulus is a complete 16-bit constant: a sweep over all 128 opcodes combined with several fixed operand patterns, plus hand-worked words for each instruction class.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

    // Instruction geometry
    localparam int INSTR_W  = 16;
    localparam int REG_W    = 3;
    localparam int FS_W     = 4;
    localparam int CLASS_W  = 3;

    // Field anchors inside the instruction word
    localparam int SRCB_LSB = 0;
    localparam int SRCA_LSB = SRCB_LSB + REG_W;
    localparam int DEST_LSB = SRCA_LSB + REG_W;
    localparam int FS_LSB   = DEST_LSB + REG_W;
    localparam int CLASS_LSB = INSTR_W - CLASS_W;

    // Control word, most significant field first
    typedef struct packed {
        logic [REG_W-1:0] dest_sel;
        logic [REG_W-1:0] srca_sel;
        logic [REG_W-1:0] srcb_sel;
        logic             const_sel;
        logic [FS_W-1:0]  func_sel;
        logic             load_sel;
        logic             reg_we;
        logic             mem_we;
        logic             pc_load;
        logic             jump_sel;
        logic             cond_neg;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ctl_dec_route.sv
module ctl_dec_route
    import ctl_dec_pkg::*;
(
    input  logic [3*REG_W-1:0] reg_fields,
    output logic [REG_W-1:0]   dest_sel,
    output logic [REG_W-1:0]   srca_sel,
    output logic [REG_W-1:0]   srcb_sel
);

    // Register selects are copied straight from their instruction slots
    always_comb begin
        dest_sel = reg_fields[DEST_LSB +: REG_W];
        srca_sel = reg_fields[SRCA_LSB +: REG_W];
        srcb_sel = reg_fields[SRCB_LSB +: REG_W];
    end

endmodule

// File: rtl/ctl_dec_class.sv
module ctl_dec_class
    import ctl_dec_pkg::*;
(
    input  logic [CLASS_W-1:0] class_bits,
    input  logic               low_opc_bit,
    output logic               const_sel,
    output logic               load_sel,
    output logic               reg_we,
    output logic               mem_we,
    output logic               pc_load,
    output logic               jump_sel,
    output logic               cond_neg
);

    logic top_b;
    logic mid_b;
    logic low_b;

    always_comb begin
        top_b = class_bits[2];
        mid_b = class_bits[1];
        low_b = class_bits[0];
    end

    // Class codes were chosen so each signal is one bit or one AND term
    always_comb begin
        const_sel = top_b;
        load_sel  = low_b;
        reg_we    = ~mid_b;
        mem_we    = ~top_b & mid_b;
        pc_load   = top_b & mid_b;
        jump_sel  = low_b;
        cond_neg  = low_opc_bit;
    end

endmodule

// File: rtl/ctl_dec_fsel.sv
module ctl_dec_fsel
    import ctl_dec_pkg::*;
(
    input  logic [FS_W-1:0] opc_low,
    input  logic            pc_load,
    output logic [FS_W-1:0] func_sel
);

    // Upper function bits pass through; the shared lowest bit is
    // masked whenever the program counter is loaded
    generate
        for (genvar g = 1; g < FS_W; g++) begin : g_pass
            assign func_sel[g] = opc_low[g];
        end
    endgenerate

    assign func_sel[0] = opc_low[0] & ~pc_load;

endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_dec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_word,
    output logic [CTRL_W-1:0]  ctrl_word
);

    ctrl_t ctl;

    ctl_dec_route u_route (
        .reg_fields (instr_word[3*REG_W-1:0]),
        .dest_sel   (ctl.dest_sel),
        .srca_sel   (ctl.srca_sel),
        .srcb_sel   (ctl.srcb_sel)
    );

    ctl_dec_class u_class (
        .class_bits  (instr_word[CLASS_LSB +: CLASS_W]),
        .low_opc_bit (instr_word[FS_LSB]),
        .const_sel   (ctl.const_sel),
        .load_sel    (ctl.load_sel),
        .reg_we      (ctl.reg_we),
        .mem_we      (ctl.mem_we),
        .pc_load     (ctl.pc_load),
        .jump_sel    (ctl.jump_sel),
        .cond_neg    (ctl.cond_neg)
    );

    ctl_dec_fsel u_fsel (
        .opc_low  (instr_word[FS_LSB +: FS_W]),
        .pc_load  (ctl.pc_load),
        .func_sel (ctl.func_sel)
    );

    assign ctrl_word = ctl;

endmodule

// File: rtl/ctl_decode_chk.sv
module ctl_decode_chk
    import ctl_dec_pkg::*;
(
    input logic [INSTR_W-1:0] instr_word,
    input logic [CTRL_W-1:0]  ctrl_word
);

    always_comb begin
        if (!$isunknown(instr_word)) begin
            // R1
            addr_pass_chk: assert (ctrl_word[19:11] == instr_word[8:0])
                else $error("register selects differ from instruction");
            // R3
            fs_mask_chk: assert (!(ctrl_word[2] && ctrl_word[6]))
                else $error("function bit 0 set during PC load");
            // R7
            we_excl_chk: assert (!(ctrl_word[3] && ctrl_word[4]))
                else $error("memory and register write both set");
            // R8
            pc_quiet_chk: assert (!ctrl_word[2] || (!ctrl_word[3] && !ctrl_word[4]))
                else $error("write enabled during PC load");
            // R4
            const_cls_chk: assert (instr_word[15:13] != 3'b100 ||
                                   (ctrl_word[10] && !ctrl_word[5] && ctrl_word[4]))
                else $error("constant class decoded wrongly");
            // R5
            load_cls_chk: assert (instr_word[15:13] != 3'b001 ||
                                  (ctrl_word[5] && ctrl_word[4] && !ctrl_word[10]))
                else $error("memory read class decoded wrongly");
        end
    end

endmodule

bind ctl_decode ctl_decode_chk u_chk (
    .instr_word (instr_word),
    .ctrl_word  (ctrl_word)
);

// File: tb/test_ctl_decode.sv
module test_ctl_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic [19:0] ctrl_word;
    int          total = 0;
    int          bad = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    ctl_decode i_ctl_decode (
        .instr_word (instr_word),
        .ctrl_word  (ctrl_word)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s instr=%h actual=%h expected=%h", req, instr_word, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] w);
        @(negedge clk);
        instr_word = w;
        #5;
    endtask

    // Expected control word built field by field from the requirements
    function automatic logic [19:0] model(input logic [15:0] w);
        logic pl;
        logic [3:0] fs;
        pl = w[15] & w[14];
        fs = pl ? {w[12:10], 1'b0} : w[12:9];
        return {w[8:6], w[5:3], w[2:0], w[15], fs, w[13], ~w[14],
                ~w[15] & w[14], pl, w[13], w[9]};
    endfunction

    task automatic t_reset_state;
        apply(16'h0000);
        chk("R10 reset-state zero word", ctrl_word, 20'h00010);
    endtask

    task automatic t_worked_examples;
        apply(16'h84BB);   // add-immediate, dest 2, srcA 7, const 3
        chk("R4 add-immediate word", ctrl_word, 20'h5DC90);
        chk("R10 add-immediate word", ctrl_word, 20'h5DC90);
        apply(16'h4025);   // store, srcA 4, srcB 5
        chk("R7 store word", ctrl_word, 20'h12808);
        apply(16'hC174);   // branch on zero, offset -20
        chk("R8 branch-zero word", ctrl_word, 20'hBA404);
        apply(16'hC374);   // branch on negative
        chk("R9 branch-negative word", ctrl_word, 20'hBA405);
        chk("R3 branch-negative function masked", {16'h0, ctrl_word[9:6]}, 20'h0);
        apply(16'hE018);   // jump through srcA 3
        chk("R9 jump word", ctrl_word, 20'h0C426);
    endtask

    task automatic t_class_table;
        apply(16'h2000);   // memory read class
        chk("R5 read class mux/we", {15'h0, ctrl_word[10], ctrl_word[5:2]}, {15'h0, 1'b0, 4'b1100});
        apply(16'h1200);   // register op with bit 9 set, not PC load
        chk("R2 function bit 0 kept", {16'h0, ctrl_word[9:6]}, {16'h0, 4'b1001});
        chk("R6 register op writes", {19'h0, ctrl_word[4]}, 20'h1);
        apply(16'hDE00);   // PC load with upper function bits set
        chk("R3 upper function bits kept", {16'h0, ctrl_word[9:6]}, {16'h0, 4'b1110});
    endtask

    task automatic t_sweep;
        logic [8:0] pats [4] = '{9'h000, 9'h1FF, 9'h0AA, 9'h155};
        for (int op = 0; op < 128; op++) begin
            for (int p = 0; p < 4; p++) begin
                logic [15:0] w;
                logic [19:0] e;
                w = {op[6:0], pats[p]};
                e = model(w);
                apply(w);
                chk("R1 register selects", {11'h0, ctrl_word[19:11]}, {11'h0, e[19:11]});
                chk("R2/R3 function select", {16'h0, ctrl_word[9:6]}, {16'h0, e[9:6]});
                chk("R4 R5 R6 R7 R8 R9 control bits",
                    {13'h0, ctrl_word[10], ctrl_word[5:0]}, {13'h0, e[10], e[5:0]});
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_worked_examples();
        t_class_table();
        t_sweep();
        done = 1'b1;
    end

    initial begin
        wait (done || cycles >= 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<5000", cycles);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule